// File: doc/BRIEF.md
# Serial Link PHY Initialization Controller

This block is the state machine that takes a serial storage link from reset to a usable, ready condition. After reset it waits for out-of-band (OOB) signalling to finish, then runs speed negotiation, and only when a speed lock is reported does it raise PHY ready. The OOB completion event can come from either of two sources: the SerDes's own decoder or an internal decoder. A configuration bit picks which one is used. The analog front end, the OOB burst detection, clocking and power management are outside the block and appear only as simple event inputs.

Speed negotiation can run in a round-based mode. In this mode each round offers exactly one receive speed. The first round offers the fastest speed, and each later round offers the next slower one. When a round times out without lock, the block pulses a request for the host to issue a reset sequence. It then waits for that reset before it reruns OOB. If the slowest round also fails, a failure flag is raised and the block stays not-ready until the host resets it.

Once the link is ready, loss of signal is watched in one of two ways. With the filter enabled, one cycle of signal loss or invalid receive data drops ready. With the filter disabled, signal-detect must stay low for a programmable number of cycles before ready drops. A force-ready bit skips OOB and negotiation completely and holds the transmitter out of electrical idle.

Top module: `link_init_ctrl`

## Requirements
- R1: While reset is held and after it is released, phy_ready, reset_req and neg_fail are 0, tx_idle is 1 (force-ready clear), and in round mode rx_spd_mask is 3'b100.
- R2: With cfg_oob_sel=0 only oob_serdes_done ends the OOB phase; with cfg_oob_sel=1 only oob_int_done does, and the other event is ignored (the block stays in OOB with tx_idle=1).
- R3: With cfg_rsn_en=1, rx_spd_mask always has exactly one bit set: bit 2 is the fastest speed, bit 1 the middle and bit 0 the slowest. The first round after reset uses bit 2.
- R4: If cfg_lock_timeout cycles pass in negotiation without spd_lock, reset_req is high for exactly one cycle and the mask steps to the next slower speed. The block then waits, with tx_idle=1, for host_reset before it restarts OOB.
- R5: spd_lock during negotiation raises phy_ready on the next cycle. tx_idle is 0 during negotiation and ready, and 1 during OOB, while waiting for the host, and in failure.
- R6: A timeout in the slowest round sets neg_fail without a reset_req pulse and keeps phy_ready at 0. neg_fail stays set until host_reset, which clears it and restarts OOB at the fastest speed.
- R7: With cfg_filter_en=1, one sampled cycle in ready with sig_det=0 or rx_data_valid=0 drops phy_ready on the next cycle and restarts OOB, with tx_idle=1, at the fastest speed.
- R8: With cfg_filter_en=0, ready drops only after cfg_sd_hold consecutive cycles of sig_det=0. Shorter low runs and rx_data_valid=0 are ignored.
- R9: With cfg_force_ready=1, phy_ready is 1 from the first cycle after reset, tx_idle is 0 (including during reset), and sig_det is ignored.
- R10: With cfg_rsn_en=0, rx_spd_mask is 3'b111. Every timeout pulses reset_req and retries, and neg_fail never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_filter_en | input | 1 | Single-glitch drop of ready when 1 |
| cfg_rsn_en | input | 1 | One speed per negotiation round when 1 |
| cfg_force_ready | input | 1 | Bypass OOB and negotiation |
| cfg_oob_sel | input | 1 | OOB source: 0 SerDes-decoded, 1 internal |
| cfg_lock_timeout | input | TMR_W | Cycles allowed per round for speed lock |
| cfg_sd_hold | input | HOLD_W | Consecutive low signal-detect cycles to drop ready (filter off) |
| sig_det | input | 1 | Signal detect |
| rx_data_valid | input | 1 | Receive data valid |
| oob_serdes_done | input | 1 | OOB complete, SerDes decoder |
| oob_int_done | input | 1 | OOB complete, internal decoder |
| spd_lock | input | 1 | Speed lock achieved |
| host_reset | input | 1 | Host has issued its reset sequence |
| phy_ready | output | 1 | Link ready |
| rx_spd_mask | output | N_SPEEDS | Allowed receive speeds, MSB fastest |
| tx_idle | output | 1 | Transmit electrical-idle control |
| reset_req | output | 1 | One-cycle request for a host reset sequence |
| neg_fail | output | 1 | Sticky negotiation failure |

## Verification
The assertions check several properties on every cycle: that force-ready always leads to ready, that reset_req never lasts more than one cycle, that failure and ready never coincide, that the mask is one-hot in round mode, that neg_fail persists until host_reset, and that a filtered glitch in ready always drops it. Some behaviours can only be shown by the bench's directed scenarios: the exact timeout cycle, the order in which speeds step down, the restart at the fastest speed, the consecutive-cycle count needed with the filter off, and the OOB source selection.

// File: rtl/link_init_ctrl.sv
module link_init_ctrl #(
  parameter int N_SPEEDS = 3,
  parameter int TMR_W    = 16,
  parameter int HOLD_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_filter_en,
  input  logic                cfg_rsn_en,
  input  logic                cfg_force_ready,
  input  logic                cfg_oob_sel,
  input  logic [TMR_W-1:0]    cfg_lock_timeout,
  input  logic [HOLD_W-1:0]   cfg_sd_hold,
  input  logic                sig_det,
  input  logic                rx_data_valid,
  input  logic                oob_serdes_done,
  input  logic                oob_int_done,
  input  logic                spd_lock,
  input  logic                host_reset,
  output logic                phy_ready,
  output logic [N_SPEEDS-1:0] rx_spd_mask,
  output logic                tx_idle,
  output logic                reset_req,
  output logic                neg_fail
);
  localparam int RW = (N_SPEEDS > 1) ? $clog2(N_SPEEDS) : 1;
  localparam logic [RW-1:0] LAST_RND = RW'(N_SPEEDS - 1);
  localparam logic [N_SPEEDS-1:0] FASTEST = N_SPEEDS'(1) << (N_SPEEDS - 1);

  typedef enum logic [2:0] {ST_OOB, ST_NEG, ST_WAIT, ST_FAIL, ST_READY} st_t;

  st_t st, st_n;
  logic [RW-1:0]     rnd;
  logic [TMR_W-1:0]  tmr;
  logic [HOLD_W-1:0] lowcnt;

  wire oob_ev   = cfg_oob_sel ? oob_int_done : oob_serdes_done;
  wire [TMR_W:0]  tmr_inc = {1'b0, tmr} + 1'b1;
  wire [HOLD_W:0] low_inc = {1'b0, lowcnt} + 1'b1;
  wire tmo      = tmr_inc >= {1'b0, cfg_lock_timeout};
  wire sd_lost  = !sig_det && (low_inc >= {1'b0, cfg_sd_hold});
  wire drop     = cfg_filter_en ? !(sig_det && rx_data_valid) : sd_lost;
  wire last_rnd = cfg_rsn_en && (rnd == LAST_RND);

  always_comb begin
    st_n = st;
    if (cfg_force_ready) st_n = ST_READY;
    else begin
      case (st)
        ST_OOB:   if (oob_ev) st_n = ST_NEG;
        ST_NEG:   if (spd_lock) st_n = ST_READY;
                  else if (tmo) st_n = last_rnd ? ST_FAIL : ST_WAIT;
        ST_WAIT,
        ST_FAIL:  if (host_reset) st_n = ST_OOB;
        ST_READY: if (drop) st_n = ST_OOB;
        default:  st_n = ST_OOB;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_OOB;
      rnd       <= '0;
      tmr       <= '0;
      lowcnt    <= '0;
      reset_req <= 1'b0;
      neg_fail  <= 1'b0;
    end else begin
      st        <= st_n;
      reset_req <= (st == ST_NEG) && (st_n == ST_WAIT);
      neg_fail  <= (st_n == ST_FAIL);
      tmr       <= (st == ST_NEG) ? tmr_inc[TMR_W-1:0] : '0;
      lowcnt    <= (st == ST_READY && !sig_det) ? low_inc[HOLD_W-1:0] : '0;
      if (st_n == ST_OOB && (st == ST_READY || st == ST_FAIL))
        rnd <= '0;
      else if (st == ST_NEG && st_n == ST_WAIT && cfg_rsn_en)
        rnd <= rnd + 1'b1;
    end
  end

  assign phy_ready   = (st == ST_READY);
  assign rx_spd_mask = cfg_rsn_en ? (FASTEST >> rnd) : {N_SPEEDS{1'b1}};
  assign tx_idle     = !cfg_force_ready &&
                       (st == ST_OOB || st == ST_WAIT || st == ST_FAIL);
endmodule

module link_init_chk #(
  parameter int N_SPEEDS = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_filter_en,
  input logic                cfg_rsn_en,
  input logic                cfg_force_ready,
  input logic                sig_det,
  input logic                rx_data_valid,
  input logic                host_reset,
  input logic                phy_ready,
  input logic [N_SPEEDS-1:0] rx_spd_mask,
  input logic                reset_req,
  input logic                neg_fail
);
  // R9
  force_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_force_ready |=> phy_ready);
  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  // R6
  fail_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    neg_fail |-> !phy_ready);
  // R6
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    neg_fail && !host_reset && !cfg_force_ready |=> neg_fail);
  // R3
  one_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rsn_en |-> $countones(rx_spd_mask) == 1);
  // R7
  glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_ready && cfg_filter_en && !cfg_force_ready && !(sig_det && rx_data_valid)
    |=> !phy_ready);
endmodule

bind link_init_ctrl link_init_chk #(.N_SPEEDS(N_SPEEDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_filter_en(cfg_filter_en),
  .cfg_rsn_en(cfg_rsn_en), .cfg_force_ready(cfg_force_ready),
  .sig_det(sig_det), .rx_data_valid(rx_data_valid), .host_reset(host_reset),
  .phy_ready(phy_ready), .rx_spd_mask(rx_spd_mask), .reset_req(reset_req),
  .neg_fail(neg_fail));

// File: tb/tb_link_init_ctrl.sv
module tb_link_init_ctrl;
  logic clk = 0, rst_n = 0;
  logic cfg_filter_en = 1, cfg_rsn_en = 1, cfg_force_ready = 0, cfg_oob_sel = 0;
  logic [15:0] cfg_lock_timeout = 16'd4;
  logic [7:0]  cfg_sd_hold = 8'd3;
  logic sig_det = 1, rx_data_valid = 1, oob_serdes_done = 0, oob_int_done = 0;
  logic spd_lock = 0, host_reset = 0;
  logic phy_ready, tx_idle, reset_req, neg_fail;
  logic [2:0] rx_spd_mask;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  link_init_ctrl dut (.*);

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    step(2); rst_n = 1;
  endtask

  task automatic oob_pass();
    oob_serdes_done = 1; step(); oob_serdes_done = 0;
  endtask

  task automatic host_pulse();
    host_reset = 1; step(); host_reset = 0;
  endtask

  task automatic lock_pulse();
    spd_lock = 1; step(); spd_lock = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 0; step();
    chk("R1 tx_idle in reset", tx_idle, 1);
    rst_n = 1;
    step(3);
    chk("R1 ready", phy_ready, 0);
    chk("R1 tx_idle", tx_idle, 1);
    chk("R1 reset_req", reset_req, 0);
    chk("R1 neg_fail", neg_fail, 0);
    chk("R1 mask", rx_spd_mask, 3'b100);
  endtask

  task automatic t_oob_sel();
    do_reset();
    cfg_oob_sel = 1;
    oob_pass(); step();
    chk("R2 serdes ignored", tx_idle, 1);
    oob_int_done = 1; step(); oob_int_done = 0;
    chk("R2 internal accepted", tx_idle, 0);
    chk("R3 first round fastest", rx_spd_mask, 3'b100);
    do_reset();
    cfg_oob_sel = 0;
    oob_int_done = 1; step(); oob_int_done = 0;
    chk("R2 internal ignored", tx_idle, 1);
    oob_pass();
    chk("R2 serdes accepted", tx_idle, 0);
  endtask

  task automatic t_rounds();
    do_reset();
    oob_pass();
    chk("R3 round0 mask", rx_spd_mask, 3'b100);
    step(3);
    chk("R4 no early timeout", reset_req, 0);
    chk("R5 tx_idle in negotiation", tx_idle, 0);
    step();
    chk("R4 reset_req pulse", reset_req, 1);
    chk("R4 mask steps down", rx_spd_mask, 3'b010);
    chk("R4 idle while waiting", tx_idle, 1);
    step();
    chk("R4 pulse one cycle", reset_req, 0);
    step(2);
    chk("R4 still waiting", tx_idle, 1);
    host_pulse(); oob_pass();
    chk("R4 second round negotiating", tx_idle, 0);
    step(4);
    chk("R4 second pulse", reset_req, 1);
    chk("R3 slowest mask", rx_spd_mask, 3'b001);
    host_pulse(); oob_pass(); step(4);
    chk("R6 fail set", neg_fail, 1);
    chk("R6 no reset_req", reset_req, 0);
    chk("R6 not ready", phy_ready, 0);
    step(3);
    chk("R6 sticky", neg_fail, 1);
    host_pulse();
    chk("R6 cleared by host", neg_fail, 0);
    chk("R6 restart fastest", rx_spd_mask, 3'b100);
    chk("R6 back in OOB", tx_idle, 1);
  endtask

  task automatic t_lock();
    do_reset(); oob_pass(); lock_pulse();
    chk("R5 ready on lock", phy_ready, 1);
    chk("R5 tx_idle off in ready", tx_idle, 0);
  endtask

  task automatic t_filter_on();
    do_reset(); oob_pass(); step(4); host_pulse(); oob_pass(); lock_pulse();
    chk("R7 ready at middle speed", rx_spd_mask, 3'b010);
    step(2);
    rx_data_valid = 0; step(); rx_data_valid = 1;
    chk("R7 dv glitch drops ready", phy_ready, 0);
    chk("R7 restart OOB", tx_idle, 1);
    chk("R7 restart fastest", rx_spd_mask, 3'b100);
    oob_pass(); lock_pulse();
    sig_det = 0; step(); sig_det = 1;
    chk("R7 sd glitch drops ready", phy_ready, 0);
  endtask

  task automatic t_filter_off();
    cfg_filter_en = 0;
    do_reset(); oob_pass(); lock_pulse();
    sig_det = 0; step(2); sig_det = 1; step();
    chk("R8 short low ignored", phy_ready, 1);
    rx_data_valid = 0; step(4);
    chk("R8 dv ignored", phy_ready, 1);
    rx_data_valid = 1;
    sig_det = 0; step(2);
    chk("R8 not yet dropped", phy_ready, 1);
    step();
    chk("R8 dropped after hold", phy_ready, 0);
    sig_det = 1;
    cfg_filter_en = 1;
  endtask

  task automatic t_force();
    cfg_force_ready = 1;
    @(negedge clk); rst_n = 0; step();
    chk("R9 tx_idle off in reset", tx_idle, 0);
    rst_n = 1; step();
    chk("R9 ready after reset", phy_ready, 1);
    chk("R9 tx_idle off", tx_idle, 0);
    sig_det = 0; rx_data_valid = 0; step(5);
    chk("R9 sig_det ignored", phy_ready, 1);
    sig_det = 1; rx_data_valid = 1;
    cfg_force_ready = 0;
  endtask

  task automatic t_no_rsn();
    cfg_rsn_en = 0;
    do_reset();
    chk("R10 all speeds", rx_spd_mask, 3'b111);
    for (int i = 0; i < 4; i++) begin
      oob_pass(); step(4);
      chk("R10 retry pulse", reset_req, 1);
      chk("R10 no fail", neg_fail, 0);
      chk("R10 mask kept", rx_spd_mask, 3'b111);
      host_pulse();
    end
    cfg_rsn_en = 1;
  endtask

  initial begin
    t_reset();
    t_oob_sel();
    t_rounds();
    t_lock();
    t_filter_on();
    t_filter_off();
    t_force();
    t_no_rsn();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule